// File: doc/BRIEF.md
# Slot-Aware Bundle Branch Predictor

This block sits in the fetch stage of a wide-issue machine that fetches one multi-slot instruction bundle per cycle. Each cycle it looks at the bundle address and a global outcome history. From these it decides whether the bundle holds a taken branch. When the answer is taken, it also names the issue slot that holds that branch. It uses that slot, together with the bundle address, to read a target buffer, so two branch slots in one bundle keep separate targets. The block returns a single predicted next address. If no branch is predicted taken, that address is the sequential bundle after the current one.

Training comes later, from execute, through a resolve port. That port carries the resolved outcome and slot, the real target, and the values the fetch stage had predicted, including the direction-table index it used. The block updates its tables and its history only at that point. Fetching a bundle never changes any state. When the carried prediction disagrees with the resolved behaviour, the block raises a one-cycle redirect with the correct next address on the following cycle.

Top module: `slot_bpred`

## Requirements
- R1: After reset, every fetch address predicts not-taken with next address equal to the fetch address plus BUNDLE_BYTES, slot 0, and `redirect_valid` is low.
- R2: The direction index `pred_dir_idx` equals the bundle-number bits of `fetch_pc` (bits starting at log2(BUNDLE_BYTES), DIR_W wide) XOR the global history; the history is zero after reset.
- R3: Each direction entry holds a 2-bit saturating counter that starts at 1 (weakly not-taken), counts up on a taken resolve and down on a not-taken resolve; a counter of 2 or 3 is required for a taken prediction.
- R4: A taken resolve stores `res_slot` in the addressed direction entry; a taken prediction reports that stored slot on `pred_slot`, and a not-taken prediction reports slot 0.
- R5: The target buffer is indexed by {low bundle-number bits of the PC, slot}, so the targets of different slots of one bundle are held apart; a taken prediction outputs the stored target on `pred_npc`.
- R6: If the target-buffer entry is empty, or its stored tag (the PC bits just above the index bits) differs, the prediction is not-taken with the fall-through address, whatever the counter holds.
- R7: History and tables change only in a cycle with `res_valid` high; the history then shifts left and takes `res_taken` into bit 0; fetch lookups alone change nothing.
- R8: One cycle after a resolve, `redirect_valid` is high exactly when the predicted direction, the predicted slot (for a taken outcome) or the predicted next address differs from the resolved one; `redirect_pc` is then the resolved target when taken, or `res_pc` plus BUNDLE_BYTES when not.
- R9: Training writes the direction entry named by `res_dir_idx`, not one recomputed from `res_pc` and the current history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address of the bundle being fetched |
| pred_taken | output | 1 | Bundle predicted to contain a taken branch |
| pred_slot | output | SLOT_W | Predicted issue slot of the taken branch |
| pred_npc | output | PC_W | Predicted next bundle address |
| pred_dir_idx | output | DIR_W | Direction index used, to be carried to resolve |
| res_valid | input | 1 | A branch bundle resolves this cycle |
| res_pc | input | PC_W | Address of the resolving bundle |
| res_dir_idx | input | DIR_W | Direction index carried from prediction |
| res_pred_taken | input | 1 | Direction that was predicted |
| res_pred_slot | input | SLOT_W | Slot that was predicted |
| res_pred_npc | input | PC_W | Next address that was predicted |
| res_taken | input | 1 | Resolved direction |
| res_slot | input | SLOT_W | Slot of the branch that resolved taken |
| res_target | input | PC_W | Resolved branch target |
| redirect_valid | output | 1 | Misprediction, fetch must restart |
| redirect_pc | output | PC_W | Correct next address after a misprediction |

## Verification
The hardest state to reach from the ports is a taken prediction itself. The counter, the slot field and a matching tagged target must all line up. On top of that, the history moves on every resolve, so the fetch index that reads a trained entry keeps shifting. The bench uses the carried index to train a chosen entry. It then issues a known run of not-taken and taken resolves that steers the history back to a value where a chosen fetch address selects that entry again. A long pseudo-random sweep then works over a small address pool. That pool makes tags and slots collide often, and the sweep compares every output against an arithmetic model of the tables.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam logic [1:0] CTR_WEAK_NT = 2'b01;

    // Saturating step of a 2-bit direction counter.
    function automatic logic [1:0] ctr_step(input logic [1:0] ctr, input logic up);
        if (up) begin
            return (ctr == 2'b11) ? ctr : ctr + 2'd1;
        end
        return (ctr == 2'b00) ? ctr : ctr - 2'd1;
    endfunction

endpackage

// File: rtl/sbp_dir_table.sv
module sbp_dir_table
    import sbp_pkg::*;
#(
    parameter int ENTRIES = 2048,
    parameter int SLOT_W  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [1:0]        rd_ctr,
    output logic [SLOT_W-1:0] rd_slot,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    input  logic [SLOT_W-1:0] wr_slot
);

    logic [1:0]        ctr_q  [ENTRIES];
    logic [SLOT_W-1:0] slot_q [ENTRIES];

    assign rd_ctr  = ctr_q[rd_idx];
    assign rd_slot = slot_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i]  <= CTR_WEAK_NT;
                slot_q[i] <= '0;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
            if (wr_taken) begin
                slot_q[wr_idx] <= wr_slot;
            end
        end
    end

endmodule

// File: rtl/sbp_target_buf.sv
module sbp_target_buf #(
    parameter int ENTRIES = 512,
    parameter int TAG_W   = 8,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    logic             valid_q  [ENTRIES];
    logic [TAG_W-1:0] tag_q    [ENTRIES];
    logic [PC_W-1:0]  target_q [ENTRIES];

    assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_target = target_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            target_q[wr_idx] <= wr_target;
        end
    end

endmodule

// File: rtl/slot_bpred.sv
module slot_bpred
    import sbp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int SLOTS        = 4,
    parameter int BUNDLE_BYTES = 16,
    parameter int DIR_ENTRIES  = 2048,
    parameter int BTB_ENTRIES  = 512,
    parameter int TAG_W        = 8,
    localparam int SLOT_W      = $clog2(SLOTS),
    localparam int DIR_W       = $clog2(DIR_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              pred_taken,
    output logic [SLOT_W-1:0] pred_slot,
    output logic [PC_W-1:0]   pred_npc,
    output logic [DIR_W-1:0]  pred_dir_idx,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic [DIR_W-1:0]  res_dir_idx,
    input  logic              res_pred_taken,
    input  logic [SLOT_W-1:0] res_pred_slot,
    input  logic [PC_W-1:0]   res_pred_npc,
    input  logic              res_taken,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic [PC_W-1:0]   res_target,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc
);

    localparam int OFS   = $clog2(BUNDLE_BYTES);
    localparam int BTB_W = $clog2(BTB_ENTRIES);
    localparam int SET_W = BTB_W - SLOT_W;
    localparam logic [PC_W-1:0] STEP = PC_W'(BUNDLE_BYTES);

    typedef struct packed {
        logic [DIR_W-1:0] hist;
        logic             redir_v;
        logic [PC_W-1:0]  redir_pc;
    } state_t;

    state_t st_d, st_q;

    logic [DIR_W-1:0]  fetch_idx;
    logic [1:0]        rd_ctr;
    logic [SLOT_W-1:0] rd_slot;
    logic [BTB_W-1:0]  btb_rd_idx;
    logic [TAG_W-1:0]  fetch_tag;
    logic              btb_hit;
    logic [PC_W-1:0]   btb_target;
    logic [BTB_W-1:0]  btb_wr_idx;
    logic [TAG_W-1:0]  res_tag;
    logic              btb_wr_en;
    logic [PC_W-1:0]   actual_npc;
    logic              mispredict;
    logic [DIR_W-1:0]  hist_q;

    assign hist_q = st_q.hist;

    // Fetch-side indexing: history folded into the bundle number.
    assign fetch_idx  = fetch_pc[OFS +: DIR_W] ^ st_q.hist;
    assign btb_rd_idx = {fetch_pc[OFS +: SET_W], rd_slot};
    assign fetch_tag  = fetch_pc[OFS + SET_W +: TAG_W];

    // Resolve-side indexing uses the resolved slot.
    assign btb_wr_idx = {res_pc[OFS +: SET_W], res_slot};
    assign res_tag    = res_pc[OFS + SET_W +: TAG_W];
    assign btb_wr_en  = res_valid && res_taken;

    sbp_dir_table #(
        .ENTRIES (DIR_ENTRIES),
        .SLOT_W  (SLOT_W)
    ) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_idx),
        .rd_ctr   (rd_ctr),
        .rd_slot  (rd_slot),
        .wr_en    (res_valid),
        .wr_idx   (res_dir_idx),
        .wr_taken (res_taken),
        .wr_slot  (res_slot)
    );

    sbp_target_buf #(
        .ENTRIES (BTB_ENTRIES),
        .TAG_W   (TAG_W),
        .PC_W    (PC_W)
    ) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (btb_rd_idx),
        .rd_tag    (fetch_tag),
        .rd_hit    (btb_hit),
        .rd_target (btb_target),
        .wr_en     (btb_wr_en),
        .wr_idx    (btb_wr_idx),
        .wr_tag    (res_tag),
        .wr_target (res_target)
    );

    // Prediction: taken needs a taken-leaning counter and a tag hit.
    always_comb begin
        pred_taken   = rd_ctr[1] && btb_hit;
        pred_slot    = pred_taken ? rd_slot : '0;
        pred_npc     = pred_taken ? btb_target : fetch_pc + STEP;
        pred_dir_idx = fetch_idx;
    end

    // Next state: history training and redirect generation.
    always_comb begin
        st_d       = st_q;
        actual_npc = res_taken ? res_target : res_pc + STEP;
        mispredict = (res_pred_taken != res_taken)
                   || (res_taken && (res_pred_slot != res_slot))
                   || (res_pred_npc != actual_npc);
        st_d.redir_v  = res_valid && mispredict;
        st_d.redir_pc = actual_npc;
        if (res_valid) begin
            st_d.hist = {st_q.hist[DIR_W-2:0], res_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hist: '0, redir_v: 1'b0, redir_pc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.redir_v;
    assign redirect_pc    = st_q.redir_pc;

endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
    parameter int PC_W         = 32,
    parameter int BUNDLE_BYTES = 16,
    parameter int SLOT_W       = 2,
    parameter int DIR_W        = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              pred_taken,
    input logic [SLOT_W-1:0] pred_slot,
    input logic [PC_W-1:0]   pred_npc,
    input logic              res_valid,
    input logic [PC_W-1:0]   res_pc,
    input logic              res_taken,
    input logic [PC_W-1:0]   res_target,
    input logic              redirect_valid,
    input logic [PC_W-1:0]   redirect_pc,
    input logic [DIR_W-1:0]  hist
);

    localparam logic [PC_W-1:0] STEP = PC_W'(BUNDLE_BYTES);

    a_r6_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_npc == fetch_pc + STEP);

    a_r4_slot_zero_when_nt: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_slot == '0);

    a_r8_redirect_needs_resolve: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(res_valid));

    a_r8_redirect_nt_target: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !$past(res_taken)) |-> redirect_pc == $past(res_pc) + STEP);

    a_r8_redirect_t_target: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && $past(res_taken)) |-> redirect_pc == $past(res_target));

    a_r7_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(hist));

    a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> hist[0] == $past(res_taken));

endmodule

bind slot_bpred sbp_checker #(
    .PC_W         (PC_W),
    .BUNDLE_BYTES (BUNDLE_BYTES),
    .SLOT_W       (SLOT_W),
    .DIR_W        (DIR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_pc       (fetch_pc),
    .pred_taken     (pred_taken),
    .pred_slot      (pred_slot),
    .pred_npc       (pred_npc),
    .res_valid      (res_valid),
    .res_pc         (res_pc),
    .res_taken      (res_taken),
    .res_target     (res_target),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .hist           (hist_q)
);

// File: tb/sim_slot_bpred.sv
`timescale 1ns/1ps
module sim_slot_bpred;

    // Small configuration: 16-bit PC, 4 slots, 16-byte bundles,
    // 16 direction entries (4-bit history), 16 target entries, 4-bit tag.
    // PC bits: [3:0] offset, [7:4] direction bits, [5:4] target set, [9:6] tag.
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        pred_taken;
    logic [1:0]  pred_slot;
    logic [15:0] pred_npc;
    logic [3:0]  pred_dir_idx;
    logic        res_valid = 1'b0;
    logic [15:0] res_pc = '0;
    logic [3:0]  res_dir_idx = '0;
    logic        res_pred_taken = 1'b0;
    logic [1:0]  res_pred_slot = '0;
    logic [15:0] res_pred_npc = '0;
    logic        res_taken = 1'b0;
    logic [1:0]  res_slot = '0;
    logic [15:0] res_target = '0;
    logic        redirect_valid;
    logic [15:0] redirect_pc;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference tables
    logic [1:0]  mctr [16];
    logic [1:0]  mslot [16];
    bit          mbv [16];
    logic [3:0]  mtag [16];
    logic [15:0] mtgt [16];
    logic [3:0]  mhist;

    always #10 clk = ~clk;

    slot_bpred #(
        .PC_W(16), .SLOTS(4), .BUNDLE_BYTES(16),
        .DIR_ENTRIES(16), .BTB_ENTRIES(16), .TAG_W(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_slot(pred_slot), .pred_npc(pred_npc),
        .pred_dir_idx(pred_dir_idx),
        .res_valid(res_valid), .res_pc(res_pc), .res_dir_idx(res_dir_idx),
        .res_pred_taken(res_pred_taken), .res_pred_slot(res_pred_slot),
        .res_pred_npc(res_pred_npc), .res_taken(res_taken), .res_slot(res_slot),
        .res_target(res_target),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) begin
            mctr[i] = 2'b01; mslot[i] = '0; mbv[i] = 0; mtag[i] = '0; mtgt[i] = '0;
        end
        mhist = '0;
    endfunction

    function automatic void model_pred(input logic [15:0] pc, output logic [3:0] idx,
                                       output bit t, output logic [1:0] s,
                                       output logic [15:0] npc);
        logic [3:0] b;
        bit hit;
        idx = pc[7:4] ^ mhist;
        b   = {pc[5:4], mslot[idx]};
        hit = mbv[b] && (mtag[b] == pc[9:6]);
        t   = mctr[idx][1] && hit;
        s   = t ? mslot[idx] : 2'd0;
        npc = t ? mtgt[b] : pc + 16'd16;
    endfunction

    // One cycle: fetch lookup checked against the model, optional resolve,
    // redirect checked one cycle after the resolve edge.
    task automatic cycle(input logic [15:0] pc, input bit rv, input logic [15:0] rpc,
                         input logic [3:0] ridx, input bit rpt, input logic [1:0] rps,
                         input logic [15:0] rpn, input bit rt, input logic [1:0] rs,
                         input logic [15:0] rtgt);
        logic [3:0]  e_idx;
        bit          e_t;
        logic [1:0]  e_s;
        logic [15:0] e_npc;
        logic [15:0] actual;
        bit          e_redir;
        logic [3:0]  b;
        fetch_pc = pc; res_valid = rv; res_pc = rpc; res_dir_idx = ridx;
        res_pred_taken = rpt; res_pred_slot = rps; res_pred_npc = rpn;
        res_taken = rt; res_slot = rs; res_target = rtgt;
        #1;
        model_pred(pc, e_idx, e_t, e_s, e_npc);
        chk(pred_dir_idx == e_idx, "R2", "dir index", 32'(pred_dir_idx), 32'(e_idx));
        chk(pred_taken == e_t, "R3", "direction", 32'(pred_taken), 32'(e_t));
        chk(pred_slot == e_s, "R4", "slot", 32'(pred_slot), 32'(e_s));
        chk(pred_npc == e_npc, "R5", "next pc", 32'(pred_npc), 32'(e_npc));
        actual  = rt ? rtgt : rpc + 16'd16;
        e_redir = rv && ((rt != rpt) || (rt && rs != rps) || (rpn != actual));
        @(posedge clk);
        if (rv) begin
            if (rt) begin
                mctr[ridx] = (mctr[ridx] == 2'b11) ? 2'b11 : mctr[ridx] + 2'd1;
                mslot[ridx] = rs;
                b = {rpc[5:4], rs};
                mbv[b] = 1; mtag[b] = rpc[9:6]; mtgt[b] = rtgt;
            end else begin
                mctr[ridx] = (mctr[ridx] == 2'b00) ? 2'b00 : mctr[ridx] - 2'd1;
            end
            mhist = {mhist[2:0], rt};
        end
        @(negedge clk);
        res_valid = 1'b0;
        chk(redirect_valid == e_redir, "R8", "redirect flag", 32'(redirect_valid), 32'(e_redir));
        if (e_redir) begin
            chk(redirect_pc == actual, "R8", "redirect pc", 32'(redirect_pc), 32'(actual));
        end
    endtask

    task automatic fetch_only(input logic [15:0] pc);
        cycle(pc, 0, '0, '0, 0, '0, '0, 0, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        logic [15:0] lf;
        logic [15:0] pc;
        logic [3:0]  i_idx;
        bit          i_t;
        logic [1:0]  i_s;
        logic [15:0] i_npc;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: reset state across every direction index
        chk(redirect_valid == 1'b0, "R1", "redirect after reset", 32'(redirect_valid), 0);
        for (int k = 0; k < 16; k++) begin
            fetch_pc = 16'(k << 4) | 16'h0300;
            #1;
            chk(pred_taken == 1'b0, "R1", "reset direction", 32'(pred_taken), 0);
            chk(pred_npc == fetch_pc + 16'd16, "R1", "reset next pc", 32'(pred_npc), 32'(fetch_pc + 16'd16));
            chk(pred_dir_idx == 4'(k), "R2", "reset index", 32'(pred_dir_idx), 32'(k));
        end

        // R9: train entry 5 from pc 0x0040 (recomputed index would be 4)
        cycle(16'h0040, 1, 16'h0040, 4'd5, 0, 2'd0, 16'h0050, 1, 2'd2, 16'h1230);
        // history is now 1, so pc 0x0040 reads entry 5
        fetch_only(16'h0040);
        fetch_pc = 16'h0040; #1;
        chk(pred_taken == 1'b1, "R9", "carried index trained", 32'(pred_taken), 1);
        chk(pred_slot == 2'd2, "R4", "stored slot", 32'(pred_slot), 2);
        chk(pred_npc == 16'h1230, "R5", "slot 2 target", 32'(pred_npc), 32'h1230);

        // R8: wrong slot and target -> redirect to the new target
        cycle(16'h0000, 1, 16'h0040, 4'd5, 1, 2'd2, 16'h1230, 1, 2'd1, 16'h2220);
        // R8 correct not-taken predictions, steering history back to 0001
        cycle(16'h0000, 1, 16'h00F0, 4'd15, 0, 2'd0, 16'h0100, 0, 2'd0, 16'h0000);
        cycle(16'h0000, 1, 16'h00F0, 4'd15, 0, 2'd0, 16'h0100, 0, 2'd0, 16'h0000);
        cycle(16'h0000, 1, 16'h00F0, 4'd15, 0, 2'd0, 16'h0100, 0, 2'd0, 16'h0000);
        cycle(16'h0000, 1, 16'h00F0, 4'd15, 0, 2'd0, 16'h0100, 1, 2'd0, 16'h3330);
        fetch_pc = 16'h0040; #1;
        chk(pred_dir_idx == 4'd5, "R7", "history after four resolves", 32'(pred_dir_idx), 5);
        chk(pred_slot == 2'd1 && pred_npc == 16'h2220, "R5", "slot 1 target kept apart",
            32'(pred_npc), 32'h2220);

        // R6: same index and set, different tag
        fetch_pc = 16'h0140; #1;
        chk(pred_taken == 1'b0, "R6", "tag miss direction", 32'(pred_taken), 0);
        chk(pred_npc == 16'h0150, "R6", "tag miss next pc", 32'(pred_npc), 32'h0150);

        // R7: idle fetches leave history and tables untouched
        for (int k = 0; k < 4; k++) fetch_only(16'(k * 16'h0050));
        fetch_pc = 16'h0040; #1;
        chk(pred_dir_idx == 4'd5 && pred_npc == 16'h2220, "R7", "idle fetch no change",
            32'(pred_npc), 32'h2220);

        // R8: correct taken prediction raises no redirect
        cycle(16'h0040, 1, 16'h0040, 4'd5, 1, 2'd1, 16'h2220, 1, 2'd1, 16'h2220);

        // Sweep: small PC pool so tags, slots and counters collide often (R3 saturation)
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pc = {8'd0, lf[7:4], 4'd0};
            model_pred(pc, i_idx, i_t, i_s, i_npc);
            if (lf[2:0] == 3'd0) begin
                fetch_only(pc);
            end else begin
                cycle(pc, 1, pc, i_idx, i_t, i_s,
                      (lf[3:0] == 4'hF) ? i_npc ^ 16'h0010 : i_npc,
                      lf[10] | lf[11], lf[13:12], {4'd0, lf[15:14], 2'b0, lf[9], 7'd0});
            end
        end

        wrap_up();
    end

endmodule